// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block produces the effective word address for a four-beat memory burst. When a burst starts, it captures a full external address. The upper bits are held for the whole burst. The two lowest bits seed a small burst counter. On each following continue cycle the low bits step to the next beat. The upper bits never change, and the low bits wrap within the four-word block.

A static strap input picks the beat order. Low selects wrapping linear increment. High selects an interleaved order, in which the starting low bits are XORed with a beat index running 0, 1, 2, 3. An active-low clock enable freezes every register, so a burst can be stalled at any beat and resumed later. The counter steps on every continue cycle, whatever the surrounding command logic does with that beat (dummy reads and aborted writes included). Chip-enable decoding, read/write typing and the memory array sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, burst_addr reads all zeros and the beat index is zero. After reset is released, the first continue cycle gives burst_addr = 1, whichever order is selected.
- R2: A rising edge with clk_en_n low and step_sel low loads start_addr. From the next cycle burst_addr equals start_addr, in either order.
- R3: On a continue edge (clk_en_n low, step_sel high), start_addr is ignored. The upper ADDR_W-2 bits of burst_addr keep the loaded value.
- R4: With order_sel low (linear), beat k of a burst gives low bits (start + k) mod 4. So start 2 gives 2,3,0,1 and start 3 gives 3,0,1,2.
- R5: With order_sel high (interleaved), beat k gives low bits start XOR k. So start 1 gives 1,0,3,2, start 3 gives 3,2,1,0 and start 2 gives 2,3,0,1.
- R6: The fourth continue edge after a load brings the low bits back to the starting value, in either order.
- R7: A rising edge with clk_en_n high changes nothing, even when step_sel is low and start_addr is new. A later continue edge resumes from the frozen beat.
- R8: A load in the middle of a burst restarts the beat index at zero from the new starting address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| step_sel | input | 1 | 0 = load a new start address, 1 = continue the burst |
| order_sel | input | 1 | Static strap: 0 = linear order, 1 = interleaved order |
| start_addr | input | ADDR_W | External address sampled on a load edge |
| burst_addr | output | ADDR_W | Effective address: held upper bits with the burst low bits |

## Verification
The bench runs bursts from start values 1, 2 and 3 under both orders. Start 2 gives the same sequence in both orders. Starts 1 and 3 give different sequences, so they show whether the order select is honoured and whether carries are kept inside the low bits. Runs with a fifth beat check the wrap back to the start value. Other runs drive a new start_addr during continue cycles and during frozen cycles, which shows whether the address register and counter ignore it. A load in the middle of a burst, and a reset in the middle of a burst, show whether the beat index restarts at zero.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CMD_HOLD    = 2'd0,
        CMD_LOAD    = 2'd1,
        CMD_ADVANCE = 2'd2
    } cmd_e;

    // A frozen clock enable wins over both load and advance.
    function automatic cmd_e decode_cmd(input logic clk_en_n, input logic step_sel);
        if (clk_en_n)
            return CMD_HOLD;
        else if (!step_sel)
            return CMD_LOAD;
        else
            return CMD_ADVANCE;
    endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd_i,
    output logic [BEAT_W-1:0] beat_o
);

    typedef struct packed {
        logic [BEAT_W-1:0] beat;
    } beat_state_t;

    beat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (cmd_i)
            CMD_LOAD:    st_d.beat = '0;
            CMD_ADVANCE: st_d.beat = st_q.beat + 1'b1;
            default:     st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign beat_o = st_q.beat;

    // R8: a load always restarts the beat index
    assert_beat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_LOAD) |=> (beat_o == '0));

    // R6: every continue edge moves exactly one beat forward, wrapping
    assert_beat_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ADVANCE) |=> (beat_o == BEAT_W'($past(beat_o) + 1'b1)));

    // R7: a frozen edge leaves the beat index untouched
    assert_beat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_HOLD) |=> $stable(beat_o));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  cmd_e                     cmd_i,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic [ADDR_W-BEAT_W-1:0] upper_o,
    output logic [BEAT_W-1:0]        start_o
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic [BEAT_W-1:0]  start;
    } base_state_t;

    base_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_i == CMD_LOAD) begin
            st_d.upper = addr_i[ADDR_W-1:BEAT_W];
            st_d.start = addr_i[BEAT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign upper_o = st_q.upper;
    assign start_o = st_q.start;

    // R2: a load captures the whole external address
    assert_base_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_LOAD) |=> ({upper_o, start_o} == $past(addr_i)));

    // R3: outside a load the base address is never disturbed
    assert_base_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != CMD_LOAD) |=> ($stable(upper_o) && $stable(start_o)));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  order_e            order_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [BEAT_W-1:0] low_o
);

    logic [BEAT_W-1:0] linear_low;
    logic [BEAT_W-1:0] inter_low;

    // Linear order: modular add, the carry out of the top bit is dropped.
    assign linear_low = start_i + beat_i;

    // Interleaved order: per-bit XOR of start and beat index.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
        assign inter_low[b] = start_i[b] ^ beat_i[b];
    end

    always_comb begin
        unique case (order_i)
            ORDER_INTERLEAVED: low_o = inter_low;
            default:           low_o = linear_low;
        endcase
    end

    // R5: at beat zero both orders must give back the start value
    always_comb begin
        if (beat_i == '0)
            assert_beat0_start_R5: assert (low_o == start_i);
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              step_sel,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] burst_addr
);

    localparam int BEAT_W  = $clog2(BURST_LEN);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    cmd_e               cmd;
    order_e             order;
    logic [BEAT_W-1:0]  beat;
    logic [BEAT_W-1:0]  start_low;
    logic [BEAT_W-1:0]  eff_low;
    logic [UPPER_W-1:0] upper;

    assign cmd   = decode_cmd(clk_en_n, step_sel);
    assign order = order_e'(order_sel);

    burst_beat_ctr #(
        .BEAT_W (BEAT_W)
    ) u_beat_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd),
        .beat_o (beat)
    );

    burst_base_reg #(
        .ADDR_W (ADDR_W),
        .BEAT_W (BEAT_W)
    ) u_base_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (cmd),
        .addr_i  (start_addr),
        .upper_o (upper),
        .start_o (start_low)
    );

    burst_order_map #(
        .BEAT_W (BEAT_W)
    ) u_order_map (
        .order_i (order),
        .start_i (start_low),
        .beat_i  (beat),
        .low_o   (eff_low)
    );

    assign burst_addr = {upper, eff_low};

    // R2: the address seen after a load is the loaded address
    assert_out_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !step_sel) |=> (burst_addr == $past(start_addr)));

    // R4: a linear continue edge adds one to the low bits
    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && step_sel && !order_sel) |=>
        (order_sel || (burst_addr[BEAT_W-1:0] == BEAT_W'($past(burst_addr[BEAT_W-1:0]) + 1'b1))));

    // R5: an interleaved continue edge flips the bits that the beat index flips
    assert_inter_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && step_sel && order_sel) |=>
        (!order_sel || ((burst_addr[BEAT_W-1:0] ^ $past(burst_addr[BEAT_W-1:0])) == (beat ^ $past(beat)))));

    // R7: a frozen edge holds the effective address when the strap is steady
    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n) |=> ($stable(order_sel) -> $stable(burst_addr)));

endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

    localparam int ADDR_W = 18;
    localparam int VEC_N  = 28;
    localparam int VEC_W  = 3 + 2 * ADDR_W;

    logic              clk;
    logic              rst_n;
    logic              clk_en_n;
    logic              step_sel;
    logic              order_sel;
    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] burst_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    burst_addr_gen #(.ADDR_W(ADDR_W), .BURST_LEN(4)) u_burst_addr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en_n   (clk_en_n),
        .step_sel   (step_sel),
        .order_sel  (order_sel),
        .start_addr (start_addr),
        .burst_addr (burst_addr)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    // fields: clk_en_n, step_sel, order_sel, start_addr, expected burst_addr
    localparam logic [VEC_W-1:0] VEC [VEC_N] = '{
        {1'b0, 1'b0, 1'b0, 18'h3C00E, 18'h3C00E},
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h3C00F},
        {1'b0, 1'b1, 1'b0, 18'h3FFFF, 18'h3C00C},
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h3C00D},
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h3C00E},
        {1'b0, 1'b0, 1'b0, 18'h2FFFF, 18'h2FFFF},
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h2FFFC},
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h2FFFD},
        {1'b1, 1'b1, 1'b0, 18'h00000, 18'h2FFFD},
        {1'b1, 1'b0, 1'b0, 18'h3C00E, 18'h2FFFD},
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h2FFFE},
        {1'b0, 1'b0, 1'b1, 18'h01235, 18'h01235},
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h01234},
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h01237},
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h01236},
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h01235},
        {1'b0, 1'b0, 1'b1, 18'h2FFFF, 18'h2FFFF},
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h2FFFE},
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h2FFFD},
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h2FFFC},
        {1'b0, 1'b0, 1'b1, 18'h3C00E, 18'h3C00E},
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h3C00F},
        {1'b1, 1'b1, 1'b1, 18'h00000, 18'h3C00F},
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h3C00C},
        {1'b0, 1'b0, 1'b0, 18'h01235, 18'h01235},
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h01236},
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h01237},
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h01234}
    };

    string vec_tag [VEC_N] = '{
        "R2", "R3", "R4", "R4", "R6", "R2", "R4", "R4", "R7", "R7",
        "R7", "R2", "R5", "R5", "R5", "R6", "R2", "R5", "R5", "R5",
        "R2", "R5", "R7", "R5", "R8", "R8", "R4", "R4"
    };

    task automatic check(input string tag, input logic [ADDR_W-1:0] exp);
        checks++;
        if (burst_addr !== exp) begin
            errors++;
            $display("FAIL %s: burst_addr=%h expected=%h", tag, burst_addr, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge act, sample at the next falling edge.
    task automatic step(input logic cen_n, input logic stp, input logic ord,
                        input logic [ADDR_W-1:0] a);
        clk_en_n   = cen_n;
        step_sel   = stp;
        order_sel  = ord;
        start_addr = a;
        @(negedge clk);
    endtask

    initial begin
        rst_n      = 1'b0;
        clk_en_n   = 1'b0;
        step_sel   = 1'b0;
        order_sel  = 1'b0;
        start_addr = 18'h15555;
        repeat (3) @(negedge clk);
        check("R1", 18'h00000);          // reset state despite a load request
        rst_n = 1'b1;

        for (int i = 0; i < VEC_N; i++) begin
            step(VEC[i][VEC_W-1], VEC[i][VEC_W-2], VEC[i][VEC_W-3],
                 VEC[i][2*ADDR_W-1:ADDR_W]);
            check(vec_tag[i], VEC[i][ADDR_W-1:0]);
        end

        // R1: reset in the middle of a burst clears address and beat index
        step(1'b0, 1'b0, 1'b0, 18'h3C00E);
        step(1'b0, 1'b1, 1'b0, 18'h00000);
        check("R1", 18'h3C00F);
        rst_n = 1'b0;
        #2;
        check("R1", 18'h00000);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 18'h2AAAA);
        check("R1", 18'h00001);

        // R3: a new address on continue edges does not reach the upper bits
        step(1'b0, 1'b0, 1'b0, 18'h00003);
        step(1'b0, 1'b1, 1'b0, 18'h3FFFC);
        check("R3", 18'h00000);

        // R6: linear start 3 returns to 3 after four continue edges
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0, 18'h00000);
        check("R6", 18'h00003);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule